// File: doc/BRIEF.md
# Bit-Serial Phased ALU Sequencer

This block runs an n-bit arithmetic or logic operation one bit slice at a time, starting with the least significant bit. Each slice passes through up to three ordered control phases: a compute phase that evaluates every function path for that bit, a transfer phase that forces every unselected path to a neutral 0, and an output phase that places the surviving bit into the result. When a slice uses all three phases, its output phase shares a cycle with the compute phase of the next slice. A full operation therefore takes 2n+1 steps. Functions that need no transfer phase use a two-phase schedule of 2n steps.

A request is a single beat on a valid/ready input carrying both operands and a 3-bit function code. The block holds `in_ready` high only while it is idle, so a request offered during an operation waits and is never lost halfway. The result, carry and done flag are plain outputs with no back-pressure. `done` marks the one cycle in which the final bit appears. After that, the result and carry hold their values until the next request is accepted. The `phase` output shows, for every cycle, which control phases are active.

Top module: `bitser_alu`

## Requirements
- R1: `in_func` encodes 0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR, 5 XNOR, 6 ADD, 7 SUB. When `done` is high, `result` holds the bitwise function of the captured operands for codes 0 to 5.
- R2: For ADD, `result` is the low n bits of A+B and `cout` is the carry out of the top bit. The carry ripples from slice to slice, starting at bit 0.
- R3: For SUB, the block computes A + ~B + 1. `result` is the low n bits and `cout` is 1 exactly when A >= B unsigned.
- R4: NAND, NOR, ADD and SUB use the three-phase schedule. `done` is high in step 2n+1, where step 1 is the first cycle after the accepting edge.
- R5: AND, OR, XOR and XNOR use the two-phase schedule without a transfer phase. `done` is high in step 2n.
- R6: `phase` bit 0 marks compute, bit 1 marks transfer and bit 2 marks output, and it reads 0 while idle. On the three-phase schedule: step 1 shows compute only, even steps show transfer only, odd steps from 3 to 2n-1 show compute and output together, and step 2n+1 shows output only. On the two-phase schedule: odd steps show compute only and even steps show output only.
- R7: `in_ready` is high only while idle. A request offered while an operation runs is not accepted and does not change that operation's result, carry or step count.
- R8: `done` stays high for exactly one cycle. After it, `result` and `cout` stay unchanged until a new request is accepted.
- R9: For the six logic functions, `cout` is 0.
- R10: After reset, `in_ready` is 1, `done` is 0, `phase` is 0, `result` is 0 and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request is taken on this edge |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_func | input | 3 | Function code |
| result | output | W | Result register |
| cout | output | 1 | Carry out (no-borrow for SUB) |
| done | output | 1 | Final step of the operation |
| phase | output | 3 | Active control phases {output, transfer, compute} |

## Verification
The assertions assume that a request is taken only on an edge where `in_valid` and `in_ready` are both high, and that `in_valid` is otherwise free to toggle. Their stability check depends on nothing else reaching the result while the block is idle. The stimulus drives every input at the falling edge. It mixes random operands and function codes with directed carry, borrow and equal-operand cases. It also offers requests deliberately during busy steps, to show that a request blocked by low ready cannot disturb the running operation.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  typedef enum logic [2:0] {
    F_AND  = 3'd0,
    F_OR   = 3'd1,
    F_NAND = 3'd2,
    F_NOR  = 3'd3,
    F_XOR  = 3'd4,
    F_XNOR = 3'd5,
    F_ADD  = 3'd6,
    F_SUB  = 3'd7
  } func_e;

  localparam int NFUNC = 8;

  // functions whose paths are neutralized by a state-transfer phase
  function automatic logic needs_xfer(func_e f);
    return (f == F_NAND) || (f == F_NOR) || (f == F_ADD) || (f == F_SUB);
  endfunction

  function automatic logic is_arith(func_e f);
    return (f == F_ADD) || (f == F_SUB);
  endfunction
endpackage

// File: rtl/bsalu_slice.sv
// Evaluates every function path for one bit slice.
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic             a_i,
  input  logic             b_i,
  input  logic             cin_i,
  input  logic [NFUNC-1:0] sel_oh,
  output logic [NFUNC-1:0] path_o,
  output logic             cout_o
);
  logic xor_ctl_hi, xor_ctl_lo;
  logic nb;
  logic c_add, c_sub;

  // the xor path conducts only for the pattern hi=1, lo=0
  assign xor_ctl_hi = sel_oh[int'(F_XOR)];
  assign xor_ctl_lo = ~sel_oh[int'(F_XOR)];
  assign nb         = ~b_i;

  assign c_add = (a_i & b_i) | (a_i & cin_i) | (b_i & cin_i);
  assign c_sub = (a_i & nb)  | (a_i & cin_i) | (nb & cin_i);

  always_comb begin
    path_o                = '0;
    path_o[int'(F_AND)]   = a_i & b_i;
    path_o[int'(F_OR)]    = a_i | b_i;
    path_o[int'(F_NAND)]  = ~(a_i & b_i);
    path_o[int'(F_NOR)]   = ~(a_i | b_i);
    path_o[int'(F_XOR)]   = (a_i ^ b_i) & xor_ctl_hi & ~xor_ctl_lo;
    path_o[int'(F_XNOR)]  = ~(a_i ^ b_i);
    path_o[int'(F_ADD)]   = a_i ^ b_i ^ cin_i;
    path_o[int'(F_SUB)]   = a_i ^ nb ^ cin_i;
  end

  assign cout_o = sel_oh[int'(F_SUB)] ? c_sub :
                  sel_oh[int'(F_ADD)] ? c_add : 1'b0;
endmodule

// File: rtl/bsalu_neutral.sv
// Forces every unselected path to 0 and merges the survivors.
module bsalu_neutral #(
  parameter int N = 8
) (
  input  logic [N-1:0] paths_i,
  input  logic [N-1:0] sel_oh,
  output logic         y_o
);
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = paths_i[g] & sel_oh[g];
  end

  assign y_o = |gated;
endmodule

// File: rtl/bsalu_seq.sv
// Step counter and phase decode for the three- and two-phase schedules.
module bsalu_seq #(
  parameter int W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic                              full_i,
  output logic                              busy_o,
  output logic                              last_o,
  output logic                              ph_logic_o,
  output logic                              ph_xfer_o,
  output logic                              ph_out_o,
  output logic                              latch_raw_o,
  output logic                              wr_en_o,
  output logic [((W > 1) ? $clog2(W) : 1)-1:0] logic_idx_o,
  output logic [((W > 1) ? $clog2(W) : 1)-1:0] wr_idx_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam int SW = $clog2(2 * W + 2);
  localparam logic [SW-1:0] LAST_FULL = SW'(2 * W + 1);
  localparam logic [SW-1:0] LAST_RED  = SW'(2 * W);
  localparam logic [SW-1:0] MAX_LOGIC = SW'(2 * W - 1);
  localparam logic [SW-1:0] FIRST_OUT = SW'(3);

  logic [SW-1:0] step;
  logic [SW-1:0] half, half_m1;
  logic [SW-1:0] last_step;
  logic          odd;

  assign last_step = full_i ? LAST_FULL : LAST_RED;
  assign busy_o    = (step != '0);
  assign odd       = step[0];
  assign last_o    = busy_o && (step == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (start_i) step <= SW'(1);
    else if (busy_o)  step <= last_o ? '0 : step + 1'b1;
  end

  assign ph_logic_o = busy_o && odd && (step <= MAX_LOGIC);
  assign ph_xfer_o  = busy_o && full_i && !odd;
  assign ph_out_o   = busy_o && (full_i ? (odd && (step >= FIRST_OUT)) : !odd);

  assign half    = step >> 1;
  assign half_m1 = half - 1'b1;

  assign latch_raw_o = full_i && ph_logic_o;
  assign wr_en_o     = full_i ? ph_xfer_o : ph_logic_o;
  assign logic_idx_o = half[IW-1:0];
  assign wr_idx_o    = full_i ? half_m1[IW-1:0] : half[IW-1:0];
endmodule

// File: rtl/bitser_alu.sv
module bitser_alu
  import bsalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [2:0]   in_func,
  output logic [W-1:0] result,
  output logic         cout,
  output logic         done,
  output logic [2:0]   phase
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     a_q, b_q, res_q;
  func_e            func_q;
  logic             carry_q;
  logic [NFUNC-1:0] raw_q;
  logic             rawc_q;

  logic             busy, last, ph_logic, ph_xfer, ph_out;
  logic             latch_raw, wr_en, accept, full;
  logic [IW-1:0]    logic_idx, wr_idx;
  logic [NFUNC-1:0] sel_oh, live_path, merge_in;
  logic             live_c, merged;

  assign full     = needs_xfer(func_q);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign sel_oh   = NFUNC'(1) << func_q;

  bsalu_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .full_i      (full),
    .busy_o      (busy),
    .last_o      (last),
    .ph_logic_o  (ph_logic),
    .ph_xfer_o   (ph_xfer),
    .ph_out_o    (ph_out),
    .latch_raw_o (latch_raw),
    .wr_en_o     (wr_en),
    .logic_idx_o (logic_idx),
    .wr_idx_o    (wr_idx)
  );

  bsalu_slice u_slice (
    .a_i    (a_q[logic_idx]),
    .b_i    (b_q[logic_idx]),
    .cin_i  (carry_q),
    .sel_oh (sel_oh),
    .path_o (live_path),
    .cout_o (live_c)
  );

  // three-phase functions merge the latched slice, two-phase ones the live slice
  assign merge_in = full ? raw_q : live_path;

  bsalu_neutral #(.N(NFUNC)) u_neutral (
    .paths_i (merge_in),
    .sel_oh  (sel_oh),
    .y_o     (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      func_q  <= F_AND;
      res_q   <= '0;
      carry_q <= 1'b0;
      raw_q   <= '0;
      rawc_q  <= 1'b0;
    end else if (accept) begin
      a_q     <= in_a;
      b_q     <= in_b;
      func_q  <= func_e'(in_func);
      res_q   <= '0;
      carry_q <= (func_e'(in_func) == F_SUB);
      raw_q   <= '0;
      rawc_q  <= 1'b0;
    end else begin
      if (latch_raw) begin
        raw_q  <= live_path;
        rawc_q <= live_c;
      end
      if (wr_en) begin
        res_q[wr_idx] <= merged;
        if (is_arith(func_q)) carry_q <= full ? rawc_q : live_c;
      end
    end
  end

  assign result = res_q;
  assign cout   = carry_q;
  assign done   = last;
  assign phase  = {ph_out, ph_xfer, ph_logic};
endmodule

// File: rtl/bitser_alu_chk.sv
module bitser_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [2:0]   in_func,
  input logic [W-1:0] result,
  input logic         cout,
  input logic         done,
  input logic [2:0]   phase
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(result) && $stable(cout)));

  // R7
  busy_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !done) |=> !in_ready);

  // R7
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  // R6
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (phase == 3'b000 && !done));

  // R6
  busy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (phase != 3'b000));

  // R6
  xfer_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase[1] |-> (phase == 3'b010));

  // R6
  first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (phase == 3'b001));
endmodule

bind bitser_alu bitser_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bitser_alu.sv
`timescale 1ns/1ps
module tb_bitser_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [2:0]   in_func = '0;
  logic [W-1:0] result;
  logic         cout;
  logic         done;
  logic [2:0]   phase;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bitser_alu #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // {cout, result} per R1, R2, R3, R9
  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f);
    case (f)
      3'd0: return {1'b0, a & b};
      3'd1: return {1'b0, a | b};
      3'd2: return {1'b0, ~(a & b)};
      3'd3: return {1'b0, ~(a | b)};
      3'd4: return {1'b0, a ^ b};
      3'd5: return {1'b0, ~(a ^ b)};
      3'd6: return {1'b0, a} + {1'b0, b};
      default: return {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
    endcase
  endfunction

  function automatic bit three_phase(logic [2:0] f);
    return (f == 3'd2) || (f == 3'd3) || (f == 3'd6) || (f == 3'd7);
  endfunction

  // R6 expected phase vector {out, xfer, compute} for step k
  function automatic logic [2:0] exp_phase(int k, bit full);
    logic c, x, o;
    c = (k % 2 == 1) && (k <= 2 * W - 1);
    x = full && (k % 2 == 0);
    o = full ? ((k % 2 == 1) && (k >= 3)) : (k % 2 == 0);
    return {o, x, c};
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] f, input bit poke);
    logic [W:0]   exp;
    int           k;
    int           exp_steps;
    bit           ph_ok, rdy_ok;
    logic [W-1:0] held;
    logic         held_c;
    exp       = model(a, b, f);
    exp_steps = three_phase(f) ? 2 * W + 1 : 2 * W;
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", "ready before request", 32'(in_ready), 32'd1);
    in_a = a; in_b = b; in_func = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    k = 1; ph_ok = 1'b1; rdy_ok = 1'b1;
    while (1) begin
      if (phase != exp_phase(k, three_phase(f))) ph_ok = 1'b0;
      if (in_ready) rdy_ok = 1'b0;
      if (poke && (k == 2 || k == 5)) begin
        in_a = ~a; in_b = a ^ b; in_func = f ^ 3'd1; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      if (done || k > 4 * W) break;
      k++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (three_phase(f))
      chk(k == exp_steps, "R4", "three-phase step count", 32'(k), 32'(exp_steps));
    else
      chk(k == exp_steps, "R5", "two-phase step count", 32'(k), 32'(exp_steps));
    chk(ph_ok, "R6", "phase sequence", 32'(phase), 32'(exp_phase(k, three_phase(f))));
    chk(rdy_ok, "R7", "ready low while busy", 32'(rdy_ok), 32'd1);
    if (f == 3'd6)      chk(result == exp[W-1:0], "R2", "add result", 32'(result), 32'(exp[W-1:0]));
    else if (f == 3'd7) chk(result == exp[W-1:0], "R3", "sub result", 32'(result), 32'(exp[W-1:0]));
    else                chk(result == exp[W-1:0], "R1", "logic result", 32'(result), 32'(exp[W-1:0]));
    if (f == 3'd6)      chk(cout == exp[W], "R2", "add carry", 32'(cout), 32'(exp[W]));
    else if (f == 3'd7) chk(cout == exp[W], "R3", "sub no-borrow", 32'(cout), 32'(exp[W]));
    else                chk(cout == 1'b0, "R9", "logic carry", 32'(cout), 32'd0);
    held = result; held_c = cout;
    @(negedge clk);
    chk(!done, "R8", "done single cycle", 32'(done), 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk(result == held && cout == held_c, "R8", "hold after done",
        32'({cout, result}), 32'({held_c, held}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0c3a;
    void'($urandom(seed));
    #1;
    chk(result == '0 && cout == 1'b0, "R10", "result/carry in reset", 32'({cout, result}), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0, "R10", "ready/done after reset",
        32'({in_ready, done}), 32'b10);
    chk(phase == 3'b000, "R10", "phase after reset", 32'(phase), 32'd0);
    chk(result == '0 && cout == 1'b0, "R10", "result after reset", 32'({cout, result}), 32'd0);

    // directed corners
    run_op(8'hFF, 8'h01, 3'd6, 1'b0);  // R2 carry out of top bit
    run_op(8'h80, 8'h80, 3'd6, 1'b0);  // R2
    run_op(8'h00, 8'h01, 3'd7, 1'b0);  // R3 borrow
    run_op(8'h5A, 8'h5A, 3'd7, 1'b0);  // R3 equal operands
    run_op(8'hA5, 8'h0F, 3'd4, 1'b0);  // R1 xor
    run_op(8'hC3, 8'h3C, 3'd0, 1'b1);  // R7 request during run
    run_op(8'h37, 8'h9B, 3'd7, 1'b1);  // R7 request during run
    for (int f = 0; f < 8; f++) run_op(8'h6C, 8'hA9, 3'(f), 1'b0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      run_op(W'($urandom), W'($urandom), 3'($urandom), bit'($urandom % 4 == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule